// File: doc/BRIEF.md
# Interrupt-Capable 24-Pin GPIO Controller

This block controls 24 general-purpose pins from a host register port that is 16 bits wide. Each pin is set as an output or an input. On an output pin the block drives a value written by the host. On an input pin the block samples the level through a synchronizer. An input pin can also be set to flag an interrupt condition: an active level of either polarity, a single edge of either direction, or any edge.

Per-pin events are latched into a status register. The host clears that register by writing ones to it. An enable register masks the status bits before they are merged into one interrupt line. Every 24-bit register is split across two 16-bit addresses. The per-pin trigger settings are packed into one 16-bit register for each group of eight pins.

The address map uses word addresses. Data is at 0, direction at 1, enable at 2, type at 3 and status at 4. The upper half of each of these sits 8 above its base. The trigger registers for pins 0-7, 8-15 and 16-23 are at 5, 6 and 7.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held, the direction, enable and status registers read zero, `pin_oe` is zero and `irq` is low.
- R2: For the data, direction, enable, type and status registers (base addresses 0 to 4), pin bits 15:0 read and write at the base address. Pin bits 23:16 use bits 7:0 of base+8, and bits 15:8 of that upper word read as zero.
- R3: The value written to the direction register appears on `pin_oe`, where 1 means output. The value written to the data register appears on `pin_out`. A data read returns `pin_in` once two clock cycles have passed.
- R4: A pin whose direction bit is 1 never sets its status bit, whatever its level or trigger setting.
- R5: With type bit 0 (level), the status bit of pin n is set on every cycle that the pin sits at its active level. The active level is high when bit n%8 of the trigger register for group n/8 is 1 and low when that bit is 0.
- R6: With type bit 1 (edge) and both-edge bit 0, status is set by a rising edge when the polarity bit is 1 and by a falling edge when it is 0. The opposite edge sets nothing.
- R7: With type bit 1 and bit 8+(n%8) of the group's trigger register set to 1, any change of level sets status, whatever the polarity bit holds.
- R8: Writing a 1 to a status bit clears it. Writing a 0 leaves it as it was.
- R9: When a clear write and a new event for the same pin fall on the same clock edge, the status bit stays set.
- R10: `irq` is high exactly when some pin has both its status bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, with `bus_sel` |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 24 | Pin levels from the pads |
| pin_out | output | 24 | Values driven on output pins |
| pin_oe | output | 24 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
A status clear written by the host can land on the same clock edge as a new event for that pin. The block must then keep the bit set. The bench sets up this collision in two ways. First, it clears a level-mode pin while the pin is held at its active level. Second, it toggles an edge-mode pin so that the edge reaches the end of the synchronizer exactly as the clear write is sampled. It then reads the status back and expects a 1. A later clear with no event pending must return the bit to 0.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
   // word indices of the register map (lower halves)
   localparam int unsigned IDX_DATA  = 0;
   localparam int unsigned IDX_DIR   = 1;
   localparam int unsigned IDX_EN    = 2;
   localparam int unsigned IDX_TYPE  = 3;
   localparam int unsigned IDX_STAT  = 4;
   localparam int unsigned IDX_TRIG0 = 5;
   // pins per trigger-option group
   localparam int unsigned GRP_PINS  = 8;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int unsigned PINS   = 24,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] d_i,
   output logic [PINS-1:0] q_o,
   output logic [PINS-1:0] prev_o
);
   logic [PINS-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= '0;
      else        prev_o <= stg[STAGES-1];
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig.sv
`timescale 1ns/1ps
module gpio_trig #(
   parameter int unsigned PINS = 24
) (
   input  logic [PINS-1:0] lvl_i,
   input  logic [PINS-1:0] prev_i,
   input  logic [PINS-1:0] dir_i,
   input  logic [PINS-1:0] typ_i,
   input  logic [PINS-1:0] pol_i,
   input  logic [PINS-1:0] both_i,
   output logic [PINS-1:0] ev_o
);
   logic [PINS-1:0] rise, fall, edge_hit, lvl_hit;

   assign rise     = lvl_i & ~prev_i;
   assign fall     = ~lvl_i & prev_i;
   assign edge_hit = (both_i & (rise | fall)) |
                     (~both_i & ((pol_i & rise) | (~pol_i & fall)));
   assign lvl_hit  = (pol_i & lvl_i) | (~pol_i & ~lvl_i);
   assign ev_o     = ~dir_i & ((typ_i & edge_hit) | (~typ_i & lvl_hit));
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PINS     = 24,
   parameter int unsigned BUS_W    = 16,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned HALF_OFS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   input  logic [PINS-1:0]   lvl_i,
   input  logic [PINS-1:0]   ev_i,
   output logic [PINS-1:0]   dout_o,
   output logic [PINS-1:0]   dir_o,
   output logic [PINS-1:0]   en_o,
   output logic [PINS-1:0]   typ_o,
   output logic [PINS-1:0]   pol_o,
   output logic [PINS-1:0]   both_o,
   output logic [PINS-1:0]   st_o
);
   localparam int unsigned HI_W   = PINS - BUS_W;
   localparam int unsigned GROUPS = PINS / GRP_PINS;

   if (PINS <= BUS_W || PINS > 2*BUS_W) begin : g_bad_pins
      $error("PINS must span two bus words");
   end
   if (PINS % GRP_PINS != 0 || BUS_W != 2*GRP_PINS) begin : g_bad_grp
      $error("trigger groups must be full bytes");
   end
   if (IDX_TRIG0 + GROUPS > HALF_OFS || 2*HALF_OFS > (1 << ADDR_W)) begin : g_bad_map
      $error("register map does not fit the address width");
   end

   logic [PINS-1:0]   dout_q, dir_q, en_q, typ_q, st_q;
   logic [BUS_W-1:0]  trig_q [GROUPS];
   logic              hi;
   logic [ADDR_W-1:0] idx;
   logic [PINS-1:0]   wmask, wval, clr_mask, rd_word;

   function automatic logic [PINS-1:0] place(input logic h, input logic [BUS_W-1:0] w);
      logic [PINS-1:0] r;
      r = '0;
      if (h) r[PINS-1:BUS_W] = w[HI_W-1:0];
      else   r[BUS_W-1:0]    = w;
      return r;
   endfunction

   assign hi       = addr_i >= ADDR_W'(HALF_OFS);
   assign idx      = hi ? addr_i - ADDR_W'(HALF_OFS) : addr_i;
   assign wmask    = place(hi, '1);
   assign wval     = place(hi, wdata_i);
   assign clr_mask = (wr_i && idx == ADDR_W'(IDX_STAT)) ? wval : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
         en_q   <= '0;
         typ_q  <= '0;
      end else if (wr_i) begin
         if (idx == ADDR_W'(IDX_DATA)) dout_q <= (dout_q & ~wmask) | wval;
         if (idx == ADDR_W'(IDX_DIR))  dir_q  <= (dir_q  & ~wmask) | wval;
         if (idx == ADDR_W'(IDX_EN))   en_q   <= (en_q   & ~wmask) | wval;
         if (idx == ADDR_W'(IDX_TYPE)) typ_q  <= (typ_q  & ~wmask) | wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= (st_q & ~clr_mask) | ev_i;
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_trig
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) trig_q[g] <= '0;
         else if (wr_i && !hi && idx == ADDR_W'(IDX_TRIG0 + g)) trig_q[g] <= wdata_i;
      end
      assign pol_o[g*GRP_PINS +: GRP_PINS]  = trig_q[g][GRP_PINS-1:0];
      assign both_o[g*GRP_PINS +: GRP_PINS] = trig_q[g][BUS_W-1:GRP_PINS];
   end

   always_comb begin
      case (idx)
         ADDR_W'(IDX_DATA): rd_word = lvl_i;
         ADDR_W'(IDX_DIR):  rd_word = dir_q;
         ADDR_W'(IDX_EN):   rd_word = en_q;
         ADDR_W'(IDX_TYPE): rd_word = typ_q;
         ADDR_W'(IDX_STAT): rd_word = st_q;
         default:           rd_word = '0;
      endcase
      rdata_o = hi ? BUS_W'(rd_word[PINS-1:BUS_W]) : rd_word[BUS_W-1:0];
      for (int g = 0; g < GROUPS; g++) begin
         if (!hi && idx == ADDR_W'(IDX_TRIG0 + g)) rdata_o = trig_q[g];
      end
   end

   assign dout_o = dout_q;
   assign dir_o  = dir_q;
   assign en_o   = en_q;
   assign typ_o  = typ_q;
   assign st_o   = st_q;

   // R5
   st_set_by_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q & ~$past(st_q) & ~$past(ev_i)) == '0);
   // R8
   st_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (~st_q & $past(st_q) & ~$past(clr_mask)) == '0);
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl #(
   parameter int unsigned PINS        = 24,
   parameter int unsigned BUS_W       = 16,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned HALF_OFS    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic              irq
);
   logic            wr_en;
   logic [PINS-1:0] lvl, prev, ev, dir, en, typ, pol, both, st, dout;

   assign wr_en = bus_sel & bus_wr;

   gpio_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(lvl), .prev_o(prev));

   gpio_trig #(.PINS(PINS)) u_trig (
      .lvl_i(lvl), .prev_i(prev), .dir_i(dir), .typ_i(typ),
      .pol_i(pol), .both_i(both), .ev_o(ev));

   gpio_regs #(.PINS(PINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .HALF_OFS(HALF_OFS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .rdata_o(bus_rdata), .lvl_i(lvl), .ev_i(ev),
      .dout_o(dout), .dir_o(dir), .en_o(en), .typ_o(typ), .pol_o(pol),
      .both_o(both), .st_o(st));

   assign pin_out = dout;
   assign pin_oe  = dir;
   assign irq     = |(st & en);

   // R4
   out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st & ~$past(st) & $past(dir)) == '0);
   // R10
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en != '0));
   // R3
   oe_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(pin_oe));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [23:0] pin_in = '0;
   logic [23:0] pin_out, pin_oe;
   logic        irq;

   int nchk = 0, nfail = 0;
   logic [23:0] typ_sh = '0;
   logic [15:0] trig_sh [3] = '{16'h0, 16'h0, 16'h0};

   gpio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   always #4 clk = ~clk;

   // {pin[4:0], type, pol, both, start, end, expected status}
   localparam logic [10:0] VEC [12] = '{
      {5'd3,  6'b110_011}, {5'd3,  6'b110_100}, {5'd9,  6'b100_101},
      {5'd9,  6'b100_010}, {5'd17, 6'b101_011}, {5'd17, 6'b111_101},
      {5'd20, 6'b010_000}, {5'd20, 6'b010_011}, {5'd12, 6'b000_110},
      {5'd12, 6'b000_101}, {5'd23, 6'b110_110}, {5'd0,  6'b000_101}};

   task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all bus tasks start and end at a falling edge
   task automatic wr16(input logic [3:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd16(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic wr24(input logic [3:0] a, input logic [23:0] v);
      wr16(a, v[15:0]);
      wr16(a + 4'd8, {8'h00, v[23:16]});
   endtask

   task automatic rd24(input logic [3:0] a, output logic [23:0] v);
      logic [15:0] lo, hi;
      rd16(a, lo); rd16(a + 4'd8, hi);
      v = {hi[7:0], lo};
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic set_mode(input int p, input logic t, input logic pl, input logic b);
      typ_sh[p] = t;
      trig_sh[p/8][p%8] = pl;
      trig_sh[p/8][8 + p%8] = b;
      wr24(4'd3, typ_sh);
      wr16(4'(5 + p/8), trig_sh[p/8]);
   endtask

   initial begin
      #800000;
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 24'h0, 24'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [23:0] v, w;
      logic [15:0] h;
      // R1 reset state
      repeat (3) @(negedge clk);
      rd24(4'd1, v); check("R1 dir", v, 24'h0);
      rd24(4'd2, v); check("R1 enable", v, 24'h0);
      rd24(4'd4, v); check("R1 status", v, 24'h0);
      check("R1 pin_oe", pin_oe, 24'h0);
      check("R1 irq", {23'h0, irq}, 24'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 split halves, R3 direction and data
      wr16(4'd1, 16'h1234); wr16(4'd9, 16'hFFAB);
      rd16(4'd9, h); check("R2 upper half", {8'h0, h}, 24'h0000AB);
      rd16(4'd1, h); check("R2 lower half", {8'h0, h}, 24'h001234);
      check("R3 pin_oe", pin_oe, 24'hAB1234);
      wr24(4'd0, 24'h5A0F0F);
      check("R3 pin_out", pin_out, 24'h5A0F0F);
      wr24(4'd1, 24'h0);
      pin_in = 24'h814002;
      @(negedge clk); @(negedge clk);
      rd24(4'd0, v); check("R3 data read", v, 24'h814002);

      // R4 output pin ignores active level
      pin_in[5] = 1'b1;
      set_mode(5, 1'b0, 1'b1, 1'b0);
      wr24(4'd1, 24'h000020);
      settle();
      wr24(4'd4, 24'hFFFFFF);
      settle();
      rd24(4'd4, v); check("R4 output pin status", {23'h0, v[5]}, 24'h0);
      wr24(4'd1, 24'h0);
      settle();
      rd24(4'd4, v); check("R4 input pin status", {23'h0, v[5]}, 24'h1);

      // R10 enable masking
      check("R10 irq masked", {23'h0, irq}, 24'h0);
      wr24(4'd2, 24'h000020);
      check("R10 irq enabled", {23'h0, irq}, 24'h1);
      // R9 clear while level still active
      wr16(4'd4, 16'h0020);
      rd24(4'd4, v); check("R9 level clear collision", {23'h0, v[5]}, 24'h1);
      pin_in[5] = 1'b0;
      settle();
      wr16(4'd4, 16'h0020);
      rd24(4'd4, v); check("R8 clear", {23'h0, v[5]}, 24'h0);
      check("R10 irq low", {23'h0, irq}, 24'h0);

      // R8 write of zero leaves status unchanged
      rd24(4'd4, v);
      wr24(4'd4, 24'h0);
      rd24(4'd4, w); check("R8 zero write", w, v);

      // R9 edge arrives on the clear edge
      set_mode(3, 1'b1, 1'b1, 1'b0);
      pin_in[3] = 1'b0;
      settle();
      wr16(4'd4, 16'h0008);
      pin_in[3] = 1'b1;
      @(negedge clk); @(negedge clk);
      wr16(4'd4, 16'h0008);
      rd24(4'd4, v); check("R9 edge clear collision", {23'h0, v[3]}, 24'h1);
      wr16(4'd4, 16'h0008);
      rd24(4'd4, v); check("R8 edge clear", {23'h0, v[3]}, 24'h0);

      // R5 R6 R7 trigger table
      foreach (VEC[i]) begin
         int p;
         string tag;
         p = int'(VEC[i][10:6]);
         tag = VEC[i][5] ? (VEC[i][3] ? "R7 both edge" : "R6 edge") : "R5 level";
         set_mode(p, VEC[i][5], VEC[i][4], VEC[i][3]);
         pin_in[p] = VEC[i][2];
         settle();
         wr24(4'd4, 24'hFFFFFF);
         pin_in[p] = VEC[i][1];
         settle();
         rd24(4'd4, v);
         check($sformatf("%s vec%0d", tag, i), {23'h0, v[p]}, {23'h0, VEC[i][0]});
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule